// File: doc/BRIEF.md
# Timed Li-Ion Charge Sequencer

This block steps a single Li-Ion pack through a timed charge cycle. It works only on digital qualifiers: supply presence, shutdown, pack removal, a charge-inhibit command, a fault-clear command, and comparator flags for the bulk threshold, current tapered to C/5, overvoltage, over-temperature and the recharge point. From these it decides when to run trickle current, when to run full bulk current and when the converter may switch. It also drives a charging status, a two-bit phase code and a fault flag. The current and voltage loops and the host register path are outside this block.

A cycle can start from idle only when every qualifier allows it. A pack below the bulk threshold first gets trickle current, under a timer of one quarter of the bulk time. Bulk charge then runs under the full bulk timer. When the current tapers, a top-off phase of one quarter of the bulk time follows, and the cycle ends cleanly. A timer that expires too early latches a fault. The latched fault stays through supply loss and clears only on a clear command, a shutdown edge or pack removal. Time is counted in ticks of `PRESCALE` clock cycles. The bulk time is `BULK_TICKS` ticks, and the quarter time is `BULK_TICKS/4` ticks.

Top module: `liion_charge_seq`

## Requirements
- R1: A cycle starts from idle only when the supply is present, shutdown is low, the pack is present, charging is not inhibited, no fault is latched and the recharge flag is high. Phase codes on `state_o` are idle=0, precondition=1, bulk=2, top-off=3. After reset, all outputs are low.
- R2: If the bulk-threshold flag is low at the start, the cycle enters precondition (code 1) with trickle enabled and bulk disabled, under a timer of `BULK_TICKS/4` ticks.
- R3: If the precondition timer expires, the block returns to code 0 with charging status low and the fault flag latched high.
- R4: The bulk-threshold flag moves the block into bulk (code 2) at the next edge, with bulk enabled and trickle off, under a full `BULK_TICKS` timer. A start with the flag already high goes straight to bulk. Progress wins over an expiry that falls on the same edge.
- R5: In bulk, the taper flag moves the block into top-off (code 3), which lasts `BULK_TICKS/4` ticks and then returns to code 0 without a fault.
- R6: If the bulk timer expires before the taper flag appears, the block returns to code 0 and latches the fault.
- R7: Overvoltage drops `pwm_en_o` only while it is present. The timers keep counting, and no fault is raised.
- R8: Over-temperature during a cycle turns off trickle, bulk and PWM, freezes the timers and drives the fault flag high. Each cycle of heat lengthens the phase by one clock. The flag drops when the pack cools.
- R9: A latched fault blocks any start and persists through supply loss. It clears on the clear command, on either edge of shutdown, or while the pack is removed.
- R10: After a clean finish, a new cycle starts on the first edge at which the recharge flag is high and the other start conditions hold.
- R11: Losing the supply, raising shutdown, removing the pack or inhibiting charge during a cycle returns the block to code 0 at the next edge without a fault.
- R12: The tick prescaler restarts on every phase entry. A phase of N ticks with no heat therefore shows its code for exactly N*PRESCALE+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| supply_ok_i | input | 1 | input supply present |
| shdn_i | input | 1 | shutdown request |
| removed_i | input | 1 | pack removed |
| inhibit_i | input | 1 | charge inhibit command |
| fault_clr_i | input | 1 | fault clear command pulse |
| above_bulk_i | input | 1 | cell voltage above bulk threshold |
| taper_i | input | 1 | charge current below C/5 |
| ovp_i | input | 1 | pack overvoltage |
| hot_i | input | 1 | pack over-temperature |
| below_rchg_i | input | 1 | cell voltage below recharge point |
| trickle_en_o | output | 1 | trickle current enable |
| bulk_en_o | output | 1 | bulk current enable |
| pwm_en_o | output | 1 | converter switching enable |
| charging_o | output | 1 | a charge cycle is active |
| state_o | output | 2 | phase code |
| fault_o | output | 1 | latched timer fault or active heat fault |

## Verification
The assertions check on every cycle the properties that can be stated locally. A start only happens when its qualifiers hold, and a low-voltage start enters precondition. Bulk is entered only from idle or precondition, and top-off exits only to idle. A timer fault lands in idle. Heat freezes the timer count, and a latched fault survives every cycle that has no clearing event. The exact phase lengths are shown only by the bench's sweeps: the N*PRESCALE+1 windows, their stretch under heat, and their lack of stretch under overvoltage. The same holds for the precedence of progress over a same-edge expiry, each fault-clear path and the automatic restart.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_BULK = 2'd2,
    ST_TOP  = 2'd3
  } chg_state_e;
endpackage

// File: rtl/chg_tick_gen.sv
module chg_tick_gen #(
  parameter int PRESCALE = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pc_q;
  logic          last;

  assign last   = (pc_q == PW'(PRESCALE - 1));
  assign tick_o = en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (clr_i)   pc_q <= '0;
    else if (en_i)    pc_q <= last ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/chg_phase_timer.sv
module chg_phase_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] limit_i,
  input  logic         tick_i,
  output logic         expired_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= limit_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_pkg::*;
#(
  parameter int W          = 12,
  parameter int QUARTER    = 900,
  parameter int BULK_TICKS = 3600
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         supply_ok_i,
  input  logic         shdn_i,
  input  logic         removed_i,
  input  logic         inhibit_i,
  input  logic         fault_clr_i,
  input  logic         above_bulk_i,
  input  logic         taper_i,
  input  logic         ovp_i,
  input  logic         hot_i,
  input  logic         below_rchg_i,
  input  logic         expired_i,
  output logic         run_o,
  output logic         load_o,
  output logic [W-1:0] limit_o,
  output logic         trickle_en_o,
  output logic         bulk_en_o,
  output logic         pwm_en_o,
  output logic         charging_o,
  output logic [1:0]   state_o,
  output logic         fault_o,
  output logic         fault_lat_o
);
  chg_state_e st_q, st_d;
  logic fault_q, shdn_q, set_flt, clr_flt, abort, start, active;

  assign active = (st_q != ST_IDLE);
  assign abort  = !supply_ok_i | shdn_i | removed_i | inhibit_i;
  assign start  = !abort & !fault_q & below_rchg_i;

  always_comb begin
    st_d    = st_q;
    load_o  = 1'b0;
    limit_o = W'(QUARTER);
    set_flt = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        load_o = 1'b1;
        if (above_bulk_i) begin
          st_d    = ST_BULK;
          limit_o = W'(BULK_TICKS);
        end else begin
          st_d    = ST_PRE;
        end
      end
      ST_PRE: begin
        if (abort)             st_d = ST_IDLE;
        else if (hot_i)        st_d = ST_PRE;
        else if (above_bulk_i) begin
          st_d    = ST_BULK;
          load_o  = 1'b1;
          limit_o = W'(BULK_TICKS);
        end else if (expired_i) begin
          st_d    = ST_IDLE;
          set_flt = 1'b1;
        end
      end
      ST_BULK: begin
        if (abort)          st_d = ST_IDLE;
        else if (hot_i)     st_d = ST_BULK;
        else if (taper_i) begin
          st_d   = ST_TOP;
          load_o = 1'b1;
        end else if (expired_i) begin
          st_d    = ST_IDLE;
          set_flt = 1'b1;
        end
      end
      ST_TOP: begin
        if (abort)          st_d = ST_IDLE;
        else if (hot_i)     st_d = ST_TOP;
        else if (expired_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // shutdown edges, pack removal and the clear command all drop a latched fault
  assign clr_flt = fault_clr_i | removed_i | (shdn_i ^ shdn_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      fault_q <= 1'b0;
      shdn_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      shdn_q <= shdn_i;
      if (set_flt)      fault_q <= 1'b1;
      else if (clr_flt) fault_q <= 1'b0;
    end
  end

  assign run_o        = active & !hot_i;
  assign trickle_en_o = (st_q == ST_PRE) & !hot_i;
  assign bulk_en_o    = (st_q == ST_BULK || st_q == ST_TOP) & !hot_i;
  assign pwm_en_o     = active & !hot_i & !ovp_i;
  assign charging_o   = active;
  assign state_o      = st_q;
  assign fault_o      = fault_q | (active & hot_i);
  assign fault_lat_o  = fault_q;
endmodule

// File: rtl/liion_charge_seq.sv
module liion_charge_seq #(
  parameter int PRESCALE   = 1000,
  parameter int BULK_TICKS = 3600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       shdn_i,
  input  logic       removed_i,
  input  logic       inhibit_i,
  input  logic       fault_clr_i,
  input  logic       above_bulk_i,
  input  logic       taper_i,
  input  logic       ovp_i,
  input  logic       hot_i,
  input  logic       below_rchg_i,
  output logic       trickle_en_o,
  output logic       bulk_en_o,
  output logic       pwm_en_o,
  output logic       charging_o,
  output logic [1:0] state_o,
  output logic       fault_o
);
  localparam int TW      = $clog2(BULK_TICKS + 1);
  localparam int QUARTER = BULK_TICKS / 4;

  logic          run, load, tick, expired, fault_lat;
  logic [TW-1:0] limit, tmr_cnt;

  chg_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load),
    .en_i  (run),
    .tick_o(tick)
  );

  chg_phase_timer #(.W(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .limit_i  (limit),
    .tick_i   (tick),
    .expired_o(expired),
    .cnt_o    (tmr_cnt)
  );

  chg_seq_fsm #(.W(TW), .QUARTER(QUARTER), .BULK_TICKS(BULK_TICKS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .shdn_i      (shdn_i),
    .removed_i   (removed_i),
    .inhibit_i   (inhibit_i),
    .fault_clr_i (fault_clr_i),
    .above_bulk_i(above_bulk_i),
    .taper_i     (taper_i),
    .ovp_i       (ovp_i),
    .hot_i       (hot_i),
    .below_rchg_i(below_rchg_i),
    .expired_i   (expired),
    .run_o       (run),
    .load_o      (load),
    .limit_o     (limit),
    .trickle_en_o(trickle_en_o),
    .bulk_en_o   (bulk_en_o),
    .pwm_en_o    (pwm_en_o),
    .charging_o  (charging_o),
    .state_o     (state_o),
    .fault_o     (fault_o),
    .fault_lat_o (fault_lat)
  );
endmodule

// File: rtl/liion_charge_seq_chk.sv
module liion_charge_seq_chk #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         supply_ok_i,
  input logic         shdn_i,
  input logic         removed_i,
  input logic         inhibit_i,
  input logic         fault_clr_i,
  input logic         above_bulk_i,
  input logic         hot_i,
  input logic         below_rchg_i,
  input logic         trickle_en_o,
  input logic         charging_o,
  input logic [1:0]   state_o,
  input logic         fault_o,
  input logic [W-1:0] tmr_cnt_i,
  input logic         fault_lat_i
);
  p_start_qual_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd0 && state_o != 2'd0) |->
      $past(supply_ok_i && !shdn_i && !removed_i && !inhibit_i && !fault_o && below_rchg_i));

  p_trickle_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(charging_o) && !$past(above_bulk_i)) |-> (state_o == 2'd1 && trickle_en_o));

  p_fault_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_lat_i) |-> (state_o == 2'd0 && !charging_o));

  p_bulk_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |->
      ($past(state_o) == 2'd0 || $past(state_o) == 2'd1));

  p_topoff_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd3 && state_o != 2'd3) |-> state_o == 2'd0);

  p_heat_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (charging_o && hot_i) |=> tmr_cnt_i == $past(tmr_cnt_i));

  p_fault_persist_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fault_lat_i) && !$past(fault_clr_i) && !$past(removed_i) &&
     ($past(shdn_i) == $past(shdn_i, 2))) |-> fault_lat_i);
endmodule

bind liion_charge_seq liion_charge_seq_chk #(.W(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .shdn_i      (shdn_i),
  .removed_i   (removed_i),
  .inhibit_i   (inhibit_i),
  .fault_clr_i (fault_clr_i),
  .above_bulk_i(above_bulk_i),
  .hot_i       (hot_i),
  .below_rchg_i(below_rchg_i),
  .trickle_en_o(trickle_en_o),
  .charging_o  (charging_o),
  .state_o     (state_o),
  .fault_o     (fault_o),
  .tmr_cnt_i   (tmr_cnt),
  .fault_lat_i (fault_lat)
);

// File: tb/test_liion_charge_seq.sv
module test_liion_charge_seq;
  localparam int P  = 4;
  localparam int B  = 16;
  localparam int QD = (B / 4) * P + 1;  // quarter phase length in cycles
  localparam int BD = B * P + 1;        // bulk phase length in cycles

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply = 1'b1, shdn = 1'b0, removed = 1'b0, inhibit = 1'b1, fclr = 1'b0;
  logic above = 1'b0, taper = 1'b0, ovp = 1'b0, hot = 1'b0, rchg = 1'b1;
  logic trickle, bulk, pwm, charging, fault;
  logic [1:0] state;
  int nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  liion_charge_seq #(.PRESCALE(P), .BULK_TICKS(B)) i_liion_charge_seq (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply), .shdn_i(shdn),
    .removed_i(removed), .inhibit_i(inhibit), .fault_clr_i(fclr),
    .above_bulk_i(above), .taper_i(taper), .ovp_i(ovp), .hot_i(hot),
    .below_rchg_i(rchg), .trickle_en_o(trickle), .bulk_en_o(bulk),
    .pwm_en_o(pwm), .charging_o(charging), .state_o(state), .fault_o(fault));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic start_cycle();
    inhibit = 1'b0;
    @(negedge clk);
  endtask

  // counts negedges spent in phase s; drives ovp/heat windows by index
  task automatic run_phase(input logic [1:0] s, input int of, input int ol,
                           input int hf, input int hl, output int n);
    n = 0;
    while (state == s && n < 400) begin
      n++;
      ovp = (n >= of && n < of + ol);
      hot = (n >= hf && n < hf + hl);
      #1;
      if (ovp) chk(!pwm && charging && !fault, "R7 ovp gates pwm only", pwm, 0);
      if (hot) chk(!pwm && !trickle && !bulk && fault, "R8 heat halts current", fault, 1);
      if (hl > 0 && n == hf + hl) chk(!fault && pwm, "R8 cool resumes", fault, 0);
      @(negedge clk);
    end
    ovp = 1'b0; hot = 1'b0; inhibit = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk({trickle, bulk, pwm, charging, state, fault} == 7'd0, "R1 reset state",
        {trickle, bulk, pwm, charging, state, fault}, 0);

    // R1: each blocker alone keeps the block idle
    for (int k = 0; k < 5; k++) begin
      inhibit = 1'b0;
      supply = (k != 0); shdn = (k == 1); removed = (k == 2);
      inhibit = (k == 3); rchg = (k != 4);
      repeat (3) @(negedge clk);
      chk(state == 2'd0 && !charging, "R1 blocked start", state, 0);
      supply = 1'b1; shdn = 1'b0; removed = 1'b0; inhibit = 1'b1; rchg = 1'b1;
      @(negedge clk);
    end

    // R2/R3/R8/R9/R12: precondition timeout with heat sweep and each clear path
    for (int h = 0; h < 3; h++) begin
      int hl = h * 3 + (h == 2 ? 1 : 0);
      above = 1'b0;
      start_cycle();
      chk(state == 2'd1 && trickle && !bulk && pwm, "R2 precondition entry", state, 1);
      run_phase(2'd1, 0, 0, 4, hl, n);
      chk(n == QD + hl, "R12 R2 precondition length", n, QD + hl);
      chk(state == 2'd0 && !charging && fault, "R3 precondition timeout fault", fault, 1);
      inhibit = 1'b0;
      repeat (3) @(negedge clk);
      chk(state == 2'd0, "R9 fault blocks start", state, 0);
      supply = 1'b0;
      repeat (3) @(negedge clk);
      supply = 1'b1;
      inhibit = 1'b1;
      @(negedge clk);
      chk(fault, "R9 fault survives supply loss", fault, 1);
      if (h == 0) fclr = 1'b1; else if (h == 1) removed = 1'b1; else shdn = 1'b1;
      @(negedge clk);
      fclr = 1'b0; removed = 1'b0; shdn = 1'b0;
      chk(!fault, "R9 fault cleared", fault, 0);
      @(negedge clk);
    end

    // R4/R6/R7: precondition to bulk at several points, then bulk timeout
    for (int i = 0; i < 4; i++) begin
      int d = (i == 0) ? 1 : (i == 1) ? 6 : (i == 2) ? 16 : 17;
      above = 1'b0;
      start_cycle();
      repeat (d - 1) @(negedge clk);
      above = 1'b1;
      @(negedge clk);
      chk(state == 2'd2 && bulk && !trickle, "R4 bulk entry", state, 2);
      run_phase(2'd2, (i == 1) ? 5 : 0, (i == 1) ? 10 : 0, 0, 0, n);
      chk(n == BD, "R12 R6 R7 bulk length", n, BD);
      chk(state == 2'd0 && fault, "R6 bulk timeout fault", fault, 1);
      fclr = 1'b1;
      @(negedge clk);
      fclr = 1'b0;
      @(negedge clk);
    end

    // R4/R5/R8: direct bulk start, taper at several points, top-off
    for (int i = 0; i < 4; i++) begin
      int t = (i == 0) ? 0 : (i == 1) ? 7 : (i == 2) ? 30 : 63;
      int hl = (i == 2) ? 5 : 0;
      above = 1'b1;
      start_cycle();
      chk(state == 2'd2 && bulk, "R4 direct bulk start", state, 2);
      repeat (t) @(negedge clk);
      taper = 1'b1;
      @(negedge clk);
      taper = 1'b0;
      chk(state == 2'd3 && bulk, "R5 top-off entry", state, 3);
      run_phase(2'd3, 0, 0, 2, hl, n);
      chk(n == QD + hl, "R12 R5 top-off length", n, QD + hl);
      chk(state == 2'd0 && !fault && !charging, "R5 clean finish", fault, 0);
      @(negedge clk);
    end

    // R10: auto restart on recharge flag
    rchg = 1'b0;
    inhibit = 1'b0;
    repeat (4) @(negedge clk);
    chk(state == 2'd0, "R10 waits for recharge", state, 0);
    rchg = 1'b1;
    @(negedge clk);
    chk(state == 2'd2 && charging, "R10 auto restart", state, 2);

    // R11: each abort cause during bulk
    for (int a = 0; a < 4; a++) begin
      inhibit = 1'b0;
      if (state != 2'd2) @(negedge clk);
      repeat (3) @(negedge clk);
      if (a == 0) supply = 1'b0; else if (a == 1) shdn = 1'b1;
      else if (a == 2) removed = 1'b1; else inhibit = 1'b1;
      @(negedge clk);
      chk(state == 2'd0 && !fault && !charging, "R11 abort to idle", state, 0);
      supply = 1'b1; shdn = 1'b0; removed = 1'b0; inhibit = 1'b1;
      @(negedge clk);
      inhibit = 1'b0;
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule